// File: doc/BRIEF.md
# Nibble-Wide Asynchronous SRAM Sequencer

This block sits between a synchronous host and an external asynchronous static RAM that stores 4-bit words. It turns one host request into a fully timed RAM access. A request carries an address, write data and a read/write flag. The block then drives the RAM address, an active-low select, an active-low write strobe and the data lines, and answers with a one-cycle acknowledge. Read data comes back on a held output.

Every analog timing minimum of the RAM is a parameter expressed in whole clock cycles, rounded up. These minimums are address setup, strobe width, write recovery, read access and the bus release after a read. One netlist therefore serves any speed grade and clock rate. Writes end with select and strobe rising on the same edge. As a result the RAM never turns its output drivers on around a write. The block's own data drivers are enabled only while both strobes are low.

A retention handshake lets the system drop the RAM supply. When asked, the block finishes any access in flight and parks the select high. It reports that the RAM is safe to power down. After the request is withdrawn, it waits a programmable wake-up time before it serves the host again. Requests that arrive while the block is busy are stalled by withholding acknowledge.

Top module: `nsram_ctrl`

## Requirements
- R1: While reset is asserted: select and write strobe are high (1), data drive enable is 0, acknowledge is 0 and retention-ready is 0.
- R2: A write is carried out in this order. The address is presented for AS_CYC cycles with select and strobe high. Select and strobe then fall together and stay low for exactly WP_CYC cycles while the write data is driven. The RAM then holds the written word at that address.
- R3: A read holds select low and strobe high for ACC_CYC cycles. The data lines are sampled at the end of the last of those cycles. The sampled word appears on rd_data with the acknowledge and stays unchanged until the next read samples.
- R4: Acknowledge is a single-cycle pulse. Counted in clock edges from the edge that accepts an idle request, it arrives after AS_CYC+WP_CYC+WR_CYC+1 edges for a write and after ACC_CYC+1 edges for a read.
- R5: The data drive enable is 1 only in cycles where select and strobe are both low. It is never 1 while select is low and strobe high.
- R6: The RAM address does not change from the last setup cycle until WR_CYC cycles after the strobes have risen.
- R7: After a read, select stays high for the acknowledge cycle and then HZ_CYC more cycles before a new access may start. A request presented at the read acknowledge is accepted HZ_CYC+1 edges later, so it acknowledges after HZ_CYC+ACC_CYC+2 edges.
- R8: While in retention, select is high, retention-ready is 1, and host requests produce no acknowledge and no RAM activity.
- R9: When ret_req falls, retention-ready drops at the next edge. The block stalls for WAKE_CYC cycles and then serves a waiting request, so a read held pending acknowledges WAKE_CYC+ACC_CYC+2 edges after the drop.
- R10: A retention request that arrives during an access lets the access complete normally. Retention is entered only from idle.
- R11: In idle, a retention request takes priority over a host request presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host word address |
| req_wdata | input | DATA_W | Host write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last word read, held |
| ret_req | input | 1 | Request to park the RAM for supply removal |
| ret_ok | output | 1 | RAM parked, supply may be removed |
| ram_addr | output | ADDR_W | RAM address lines |
| ram_sel_n | output | 1 | RAM select, active low |
| ram_wstb_n | output | 1 | RAM write strobe, active low |
| ram_dq_out | output | DATA_W | Data toward the RAM |
| ram_dq_oe | output | 1 | Enable for the data-line drivers |
| ram_dq_in | input | DATA_W | Data from the RAM |

## Verification
The RAM model returns the inverted word unless select has been low for the full access time. Every address of a small configuration is first written and read back in ascending order with one arithmetic data pattern. It is then rewritten and read in descending order with a second pattern, which separates address aliasing and early sampling from correct operation. Isolated operations, read-then-read and write-then-read pairs are compared against latencies computed from the parameters, which tells a correct bus-release dwell apart from a missing or extra cycle. Retention entered from idle, entered during a write and entered against a competing request checks priority, the request blackout, the wake-up count and that the contents survive.

// File: rtl/nsram_pkg.sv
package nsram_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_RECOV,
      ST_ACCESS,
      ST_ACK,
      ST_RELEASE,
      ST_RET_HOLD,
      ST_RET_WAKE
   } nsram_state_e;

   // Registered pin image of one state
   typedef struct packed {
      logic sel_n;
      logic wstb_n;
      logic drive;
      logic ack;
      logic ret_ok;
   } nsram_pins_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic nsram_pins_t pins_for(input nsram_state_e s);
      nsram_pins_t p;
      p = '{sel_n: 1'b1, wstb_n: 1'b1, drive: 1'b0, ack: 1'b0, ret_ok: 1'b0};
      case (s)
         ST_STROBE: begin
            p.sel_n  = 1'b0;
            p.wstb_n = 1'b0;
            p.drive  = 1'b1;
         end
         ST_ACCESS:   p.sel_n  = 1'b0;
         ST_ACK:      p.ack    = 1'b1;
         ST_RET_HOLD: p.ret_ok = 1'b1;
         default: ;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/nsram_timer.sv
module nsram_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/nsram_seq.sv
module nsram_seq
   import nsram_pkg::*;
#(
   parameter int AS_CYC   = 1,
   parameter int WP_CYC   = 2,
   parameter int WR_CYC   = 1,
   parameter int ACC_CYC  = 3,
   parameter int HZ_CYC   = 2,
   parameter int WAKE_CYC = 8,
   parameter int CNT_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             ret_req,
   input  logic             op_write_q,
   input  logic             tmr_expired,
   output nsram_state_e     state_d,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             accept,
   output logic             capture
);

   // Zero-length phases are skipped by picking the entry state at elaboration
   localparam nsram_state_e WR_ENTRY = (AS_CYC > 0) ? ST_SETUP : ST_STROBE;
   localparam nsram_state_e RD_EXIT  = (HZ_CYC > 0) ? ST_RELEASE : ST_IDLE;

   nsram_state_e state_q;

   function automatic logic [CNT_W-1:0] span(input nsram_state_e s);
      case (s)
         ST_SETUP:    return CNT_W'(max_of(AS_CYC, 1) - 1);
         ST_STROBE:   return CNT_W'(WP_CYC - 1);
         ST_RECOV:    return CNT_W'(WR_CYC - 1);
         ST_ACCESS:   return CNT_W'(ACC_CYC - 1);
         ST_RELEASE:  return CNT_W'(max_of(HZ_CYC, 1) - 1);
         ST_RET_WAKE: return CNT_W'(WAKE_CYC - 1);
         default:     return '0;
      endcase
   endfunction

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: begin
            if (ret_req)        state_d = ST_RET_HOLD;
            else if (req_valid) state_d = req_write ? WR_ENTRY : ST_ACCESS;
         end
         ST_SETUP:    if (tmr_expired) state_d = ST_STROBE;
         ST_STROBE:   if (tmr_expired) state_d = ST_RECOV;
         ST_RECOV:    if (tmr_expired) state_d = ST_ACK;
         ST_ACCESS:   if (tmr_expired) state_d = ST_ACK;
         ST_ACK:      state_d = op_write_q ? ST_IDLE : RD_EXIT;
         ST_RELEASE:  if (tmr_expired) state_d = ST_IDLE;
         ST_RET_HOLD: if (!ret_req)    state_d = ST_RET_WAKE;
         ST_RET_WAKE: if (tmr_expired) state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   assign tmr_load = (state_d != state_q);
   assign tmr_val  = span(state_d);
   assign accept   = (state_q == ST_IDLE) && !ret_req && req_valid;
   assign capture  = (state_q == ST_ACCESS) && tmr_expired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACK) |=> (state_q != ST_ACK)); // R4
   AST_RET_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == ST_RET_HOLD) |-> ($past(state_q) == ST_IDLE)); // R10
   AST_WAKE_FOLLOWS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RET_HOLD && !ret_req) |=> (state_q == ST_RET_WAKE)); // R9
   AST_WAKE_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RET_WAKE) |=> (state_q inside {ST_RET_WAKE, ST_IDLE})); // R9

endmodule

// File: rtl/nsram_datapath.sv
module nsram_datapath
   import nsram_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  nsram_state_e      state_d,
   input  logic [DATA_W-1:0] ram_dq_in,
   output logic              op_write_q,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_dq_out,
   output logic [DATA_W-1:0] rd_data,
   output nsram_pins_t       pins_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ram_addr   <= '0;
         op_write_q <= 1'b0;
      end else if (accept) begin
         ram_addr   <= req_addr;
         op_write_q <= req_write;
      end
   end

   // Pin controls are registered from the next state: glitch-free strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pins_q <= pins_for(ST_IDLE);
      else        pins_q <= pins_for(state_d);
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      logic wbit_q;
      logic rbit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wbit_q <= 1'b0;
            rbit_q <= 1'b0;
         end else begin
            if (accept && req_write) wbit_q <= req_wdata[i];
            if (capture)             rbit_q <= ram_dq_in[i];
         end
      end
      assign ram_dq_out[i] = wbit_q;
      assign rd_data[i]    = rbit_q;
   end

   AST_DRIVE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      pins_q.drive |-> (!pins_q.sel_n && !pins_q.wstb_n)); // R5
   AST_STROBE_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!pins_q.wstb_n) |-> (!pins_q.sel_n)); // R2
   AST_ADDR_HELD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!pins_q.wstb_n) |=> $stable(ram_addr)); // R6
   AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!capture) |=> $stable(rd_data)); // R3
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pins_q.ack |=> !pins_q.ack); // R4
   AST_RET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      pins_q.ret_ok |-> (pins_q.sel_n && !pins_q.ack)); // R8

endmodule

// File: rtl/nsram_ctrl.sv
module nsram_ctrl
   import nsram_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 4,
   parameter int AS_CYC   = 1,
   parameter int WP_CYC   = 2,
   parameter int WR_CYC   = 1,
   parameter int ACC_CYC  = 3,
   parameter int HZ_CYC   = 2,
   parameter int WAKE_CYC = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ack,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ret_req,
   output logic              ret_ok,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_sel_n,
   output logic              ram_wstb_n,
   output logic [DATA_W-1:0] ram_dq_out,
   output logic              ram_dq_oe,
   input  logic [DATA_W-1:0] ram_dq_in
);

   localparam int MAX_SPAN = max_of(max_of(max_of(AS_CYC, WP_CYC), max_of(WR_CYC, ACC_CYC)),
                                    max_of(HZ_CYC, WAKE_CYC));
   localparam int CNT_W    = $clog2(MAX_SPAN + 1);

   initial begin
      assert (ADDR_W >= 1)   else $error("ADDR_W must be at least 1");
      assert (DATA_W >= 1)   else $error("DATA_W must be at least 1");
      assert (AS_CYC >= 0)   else $error("AS_CYC must not be negative");
      assert (WP_CYC >= 1)   else $error("WP_CYC must be at least 1");
      assert (WR_CYC >= 1)   else $error("WR_CYC must be at least 1");
      assert (ACC_CYC >= 1)  else $error("ACC_CYC must be at least 1");
      assert (HZ_CYC >= 0)   else $error("HZ_CYC must not be negative");
      assert (WAKE_CYC >= 1) else $error("WAKE_CYC must be at least 1");
   end

   nsram_state_e     state_d;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   logic             accept;
   logic             capture;
   logic             op_write_q;
   nsram_pins_t      pins_q;

   nsram_timer #(.CNT_W(CNT_W)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   nsram_seq #(
      .AS_CYC   (AS_CYC),
      .WP_CYC   (WP_CYC),
      .WR_CYC   (WR_CYC),
      .ACC_CYC  (ACC_CYC),
      .HZ_CYC   (HZ_CYC),
      .WAKE_CYC (WAKE_CYC),
      .CNT_W    (CNT_W)
   ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .ret_req     (ret_req),
      .op_write_q  (op_write_q),
      .tmr_expired (tmr_expired),
      .state_d     (state_d),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .accept      (accept),
      .capture     (capture)
   );

   nsram_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) dp_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .capture    (capture),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .state_d    (state_d),
      .ram_dq_in  (ram_dq_in),
      .op_write_q (op_write_q),
      .ram_addr   (ram_addr),
      .ram_dq_out (ram_dq_out),
      .rd_data    (rd_data),
      .pins_q     (pins_q)
   );

   assign ram_sel_n  = pins_q.sel_n;
   assign ram_wstb_n = pins_q.wstb_n;
   assign ram_dq_oe  = pins_q.drive;
   assign req_ack    = pins_q.ack;
   assign ret_ok     = pins_q.ret_ok;

   AST_NO_RAM_DRIVE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_dq_oe && !ram_sel_n && ram_wstb_n)); // R5
   AST_NO_ACK_IN_RET: assert property (@(posedge clk) disable iff (!rst_n)
      ret_ok |=> (!req_ack)); // R8

endmodule

// File: tb/nsram_ctrl_tb.sv
module nsram_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW    = 6;
   localparam int DW    = 4;
   localparam int AS    = 1;
   localparam int WP    = 2;
   localparam int WR    = 1;
   localparam int ACC   = 3;
   localparam int HZ    = 2;
   localparam int WAKE  = 20;
   localparam int DEPTH = 1 << AW;
   localparam int WD_LIMIT = 50000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ack;
   logic [DW-1:0] rd_data;
   logic          ret_req = 1'b0;
   logic          ret_ok;
   logic [AW-1:0] ram_addr;
   logic          ram_sel_n;
   logic          ram_wstb_n;
   logic [DW-1:0] ram_dq_out;
   logic          ram_dq_oe;
   logic [DW-1:0] ram_dq_in;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int ack_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nsram_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .AS_CYC(AS), .WP_CYC(WP), .WR_CYC(WR),
      .ACC_CYC(ACC), .HZ_CYC(HZ), .WAKE_CYC(WAKE)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
      .rd_data(rd_data), .ret_req(ret_req), .ret_ok(ret_ok),
      .ram_addr(ram_addr), .ram_sel_n(ram_sel_n), .ram_wstb_n(ram_wstb_n),
      .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
   );

   // RAM model: data is only right once select has been low for the access time
   logic [DW-1:0] mem [DEPTH];
   int lowcnt = 0;
   always @(posedge clk) begin
      if (!ram_sel_n && ram_wstb_n) lowcnt <= lowcnt + 1;
      else                          lowcnt <= 0;
      if (!ram_sel_n && !ram_wstb_n)
         mem[ram_addr] <= ram_dq_oe ? ram_dq_out : ~ram_dq_out;
   end
   assign ram_dq_in = (!ram_sel_n && ram_wstb_n && lowcnt >= ACC-1) ?
                      mem[ram_addr] : ~mem[ram_addr];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Pin-level monitor
   bit            in_stb = 0;
   int            stb_w = 0;
   int            rec = 0;
   int            hi = 0;
   bit            last_read = 0;
   logic [AW-1:0] stb_addr = '0;
   logic [AW-1:0] prev_addr = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (req_ack) ack_cnt++;
         if (ram_dq_oe)
            check(!ram_sel_n && !ram_wstb_n, "R5 drive outside strobe", int'(ram_sel_n), 0);
         if (ret_ok)
            check(ram_sel_n && !req_ack, "R8 quiet in retention", int'(req_ack), 0);
         if (!ram_wstb_n) begin
            if (!in_stb) begin
               in_stb   = 1;
               stb_w    = 0;
               stb_addr = ram_addr;
               check(ram_addr == prev_addr, "R6 address setup", int'(ram_addr), int'(prev_addr));
            end
            stb_w++;
            check(ram_addr == stb_addr, "R6 address in strobe", int'(ram_addr), int'(stb_addr));
            check(!ram_sel_n, "R2 select with strobe", int'(ram_sel_n), 0);
         end else begin
            if (in_stb) begin
               in_stb = 0;
               check(stb_w == WP, "R2 strobe width", stb_w, WP);
               rec = WR;
            end
            if (rec > 0) begin
               check(ram_addr == stb_addr, "R6 address in recovery", int'(ram_addr), int'(stb_addr));
               rec--;
            end
         end
         if (ram_sel_n) begin
            hi++;
         end else begin
            if (hi > 0 && last_read)
               check(hi >= HZ + 1, "R7 bus release dwell", hi, HZ + 1);
            hi = 0;
            last_read = ram_wstb_n;
         end
         prev_addr = ram_addr;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == WD_LIMIT) begin
         checks++;
         fails++;
         $display("FAIL R4 watchdog: acknowledge never came actual=%0d expected=%0d", cyc, WD_LIMIT - 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   function automatic int pat1(input int a);
      return (a * 5 + 3) % 16;
   endfunction
   function automatic int pat2(input int a);
      return (a * 11 + 7) % 16;
   endfunction

   task automatic op(input bit w, input int a, input int d, input bit gap,
                     output int lat, output int rd);
      req_valid = 1'b1;
      req_write = w;
      req_addr  = AW'(a);
      req_wdata = DW'(d);
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!req_ack && lat < 500);
      rd = int'(rd_data);
      req_valid = 1'b0;
      if (gap) repeat (HZ + 1) @(negedge clk);
   endtask

   initial begin
      int lat, rd, lat2, rd2, acks0;
      repeat (3) @(negedge clk);
      check(ram_sel_n == 1'b1, "R1 reset select", int'(ram_sel_n), 1);
      check(ram_wstb_n == 1'b1, "R1 reset strobe", int'(ram_wstb_n), 1);
      check(ram_dq_oe == 1'b0, "R1 reset drive", int'(ram_dq_oe), 0);
      check(req_ack == 1'b0, "R1 reset ack", int'(req_ack), 0);
      check(ret_ok == 1'b0, "R1 reset ret_ok", int'(ret_ok), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Ascending sweep, pattern 1
      for (int a = 0; a < DEPTH; a++) begin
         op(1'b1, a, pat1(a), 1'b1, lat, rd);
         check(lat == AS + WP + WR + 1, "R4 write ack latency", lat, AS + WP + WR + 1);
      end
      for (int a = 0; a < DEPTH; a++) begin
         op(1'b0, a, 0, 1'b1, lat, rd);
         check(lat == ACC + 1, "R4 read ack latency", lat, ACC + 1);
         check(rd == pat1(a), "R3 read data ascending", rd, pat1(a));
      end
      // Descending sweep, pattern 2
      for (int a = DEPTH - 1; a >= 0; a--) op(1'b1, a, pat2(a), 1'b1, lat, rd);
      for (int a = DEPTH - 1; a >= 0; a--) begin
         op(1'b0, a, 0, 1'b1, lat, rd);
         check(rd == pat2(a), "R2 stored word descending", rd, pat2(a));
      end

      // Read data held across idle time and a write
      op(1'b0, 7, 0, 1'b1, lat, rd);
      repeat (4) @(negedge clk);
      check(int'(rd_data) == pat2(7), "R3 rd_data held idle", int'(rd_data), pat2(7));
      op(1'b1, 7, 9, 1'b1, lat, rd);
      check(int'(rd_data) == pat2(7), "R3 rd_data held over write", int'(rd_data), pat2(7));
      op(1'b0, 7, 0, 1'b1, lat, rd);
      check(rd == 9, "R3 read after rewrite", rd, 9);

      // Back-to-back: read then read, write then read
      op(1'b0, 3, 0, 1'b0, lat, rd);
      op(1'b0, 4, 0, 1'b1, lat2, rd2);
      check(lat2 == HZ + ACC + 2, "R7 stall after read", lat2, HZ + ACC + 2);
      check(rd2 == pat2(4), "R7 data after stall", rd2, pat2(4));
      op(1'b1, 10, 6, 1'b0, lat, rd);
      op(1'b0, 10, 0, 1'b1, lat2, rd2);
      check(lat2 == ACC + 2, "R4 read right after write", lat2, ACC + 2);
      check(rd2 == 6, "R4 write then read data", rd2, 6);

      // Retention against a competing read request
      acks0 = ack_cnt;
      ret_req   = 1'b1;
      req_valid = 1'b1;
      req_write = 1'b0;
      req_addr  = AW'(10);
      @(negedge clk);
      check(ret_ok == 1'b1, "R11 retention wins", int'(ret_ok), 1);
      check(ram_sel_n == 1'b1, "R11 select parked", int'(ram_sel_n), 1);
      repeat (10) @(negedge clk);
      check(ack_cnt == acks0, "R8 request ignored in retention", ack_cnt, acks0);
      check(ret_ok == 1'b1, "R8 retention held", int'(ret_ok), 1);
      ret_req = 1'b0;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
         if (lat == 1) check(ret_ok == 1'b0, "R9 ret_ok drops", int'(ret_ok), 0);
      end while (!req_ack && lat < 500);
      check(lat == WAKE + ACC + 2, "R9 wake stall", lat, WAKE + ACC + 2);
      check(int'(rd_data) == 6, "R9 contents kept", int'(rd_data), 6);
      req_valid = 1'b0;
      repeat (HZ + 1) @(negedge clk);

      // Retention requested in the middle of a write
      req_valid = 1'b1;
      req_write = 1'b1;
      req_addr  = AW'(12);
      req_wdata = DW'(11);
      lat = 0;
      @(negedge clk);
      lat++;
      ret_req = 1'b1;
      while (!req_ack && lat < 500) begin
         @(negedge clk);
         lat++;
      end
      check(lat == AS + WP + WR + 1, "R10 write completes", lat, AS + WP + WR + 1);
      check(ret_ok == 1'b0, "R10 no early retention", int'(ret_ok), 0);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      check(ret_ok == 1'b1, "R10 retention after write", int'(ret_ok), 1);
      ret_req = 1'b0;
      repeat (WAKE + 2) @(negedge clk);
      op(1'b0, 12, 0, 1'b1, lat, rd);
      check(rd == 11, "R10 write landed", rd, 11);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule